// File: doc/BRIEF.md
# Registered Add/Subtract Accumulator

This block is a clocked two's-complement arithmetic unit with a configurable word width that defaults to 16 bits. On each rising clock edge it captures two operands and two control bits into input registers. From those registered values it forms a sum or a difference and stores it in a result register that drives the output.

One control bit picks the operation: add or subtract. The other picks the first operand: either the freshly captured operand A, or the block's own current result. With the current result selected, B is added into or taken away from a running total. A registered flag marks any result that does not fit in the signed word, and it stays in step with the result it describes.

An active-low asynchronous reset clears every register. In practice the block sits behind unsynchronised sources as a small arithmetic stage. Two clock edges separate an input change from its visible result.

Top module: `addsub_accum`

## Requirements
- R1: With the registered subtract bit at 0, the result register loads the first operand plus the registered B, truncated to the word width.
- R2: With the registered subtract bit at 1, the result register loads the first operand minus the registered B. The subtraction inverts each bit of B and feeds a carry-in of 1.
- R3: `ovf_o` is 1 exactly when the signed result of the operation that produced the current `res_o` is out of range. For example, at 16 bits 7630 + 30000 sets it, and so does -32768 - 1.
- R4: With the registered accumulate bit at 1, the first operand is the current content of the result register, not the registered A. Consecutive accumulate cycles therefore chain.
- R5: Inputs pass through their own registers on one rising edge and reach `res_o` on the next. A value driven before edge k is first visible after edge k+1.
- R6: While `rst_ni` is 0, the operand registers, the control flip-flops, the result register and the overflow flag are all zero, with no clock edge needed. The first result after release is computed from the cleared registers.
- R7: Overflow is not sticky. An in-range operation that follows an overflow clears `ovf_o`.
- R8: Adding A = 0 and B = 0 with both control bits at 0 clears the result to zero.
- R9: Accumulate and subtract together take B away from the running result.
- R10: The result register holds the wrapped two's-complement value when overflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opa_i | input | W | Operand A, two's complement |
| opb_i | input | W | Operand B, two's complement |
| acc_i | input | 1 | 1: first operand is the current result; 0: operand A |
| sub_i | input | 1 | 1: subtract B; 0: add B |
| res_o | output | W | Registered result |
| ovf_o | output | 1 | Registered signed overflow of the last operation |

## Verification
A fixed sequence runs add, subtract, clear, then two accumulate steps. Each step comes one cycle after the last, so a wrong operand select, a wrong carry-in or an off-by-one latency gives a wrong value in the chain. Edge operands are tried in separate runs: the most negative value minus one, and the most positive value plus one. These set apart a correct carry-into-sign overflow test from one based on the carry-out alone. An in-range step right after an overflow shows whether the flag is sticky. Accumulate-subtract runs, with both positive and negative B, show that both control bits act together. Non-zero inputs are held while reset is asserted and again right after release, to show that the input registers themselves are cleared.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef struct packed {
    logic acc;
    logic sub;
  } ctrl_t;
endpackage

// File: rtl/addsub_in_reg.sv
module addsub_in_reg
  import addsub_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  ctrl_t        ctrl_i,
  output logic [W-1:0] a_q_o,
  output logic [W-1:0] b_q_o,
  output ctrl_t        ctrl_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q_o    <= '0;
      b_q_o    <= '0;
      ctrl_q_o <= '0;
    end else begin
      a_q_o    <= opa_i;
      b_q_o    <= opb_i;
      ctrl_q_o <= ctrl_i;
    end
  end

  assert_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (a_q_o == $past(opa_i)) && (b_q_o == $past(opb_i)) && (ctrl_q_o == $past(ctrl_i)));
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  logic [W:0] cy;
  assign cy[0] = sub_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic yb;
    assign yb       = y_i[i] ^ sub_i;
    assign sum_o[i] = x_i[i] ^ yb ^ cy[i];
    assign cy[i+1]  = (x_i[i] & yb) | (x_i[i] & cy[i]) | (yb & cy[i]);
  end

  // carry into sign bit differs from carry out of it
  assign ovf_o = cy[W] ^ cy[W-1];
endmodule

// File: rtl/addsub_accum.sv
module addsub_accum
  import addsub_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         acc_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] a_q, b_q, opx, sum;
  logic         ovf_c;
  ctrl_t        ctrl_in, ctrl_q;
  logic [W-1:0] res_q;
  logic         ovf_q;

  assign ctrl_in.acc = acc_i;
  assign ctrl_in.sub = sub_i;

  addsub_in_reg #(.W(W)) in_reg_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .ctrl_i  (ctrl_in),
    .a_q_o   (a_q),
    .b_q_o   (b_q),
    .ctrl_q_o(ctrl_q)
  );

  assign opx = ctrl_q.acc ? res_q : a_q;

  addsub_core #(.W(W)) core_i (
    .x_i  (opx),
    .y_i  (b_q),
    .sub_i(ctrl_q.sub),
    .sum_o(sum),
    .ovf_o(ovf_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      res_q <= sum;
      ovf_q <= ovf_c;
    end
  end

  assign res_o = res_q;
  assign ovf_o = ovf_q;

  assert_add_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.sub |=> res_q == ($past(opx) + $past(b_q)));

  assert_sub_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.sub |=> res_q == ($past(opx) - $past(b_q)));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ovf_q == ($past(ctrl_q.sub)
      ? (($past(opx[MSB]) != $past(b_q[MSB])) && (res_q[MSB] != $past(opx[MSB])))
      : (($past(opx[MSB]) == $past(b_q[MSB])) && (res_q[MSB] != $past(opx[MSB])))));

  assert_acc_feedback_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.acc && !ctrl_q.sub) |=> res_q == ($past(res_q) + $past(b_q)));

  assert_reset_clear_R6: assert property (@(posedge clk_i)
    !rst_ni |-> (res_q == '0) && !ovf_q && (a_q == '0) && (b_q == '0) && (ctrl_q == '0));
endmodule

// File: tb/addsub_accum_tb_top.sv
module addsub_accum_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic         acc = 1'b0, sub = 1'b0;
  logic [W-1:0] res;
  logic         ovf;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addsub_accum #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .opa_i(opa), .opb_i(opb),
    .acc_i(acc), .sub_i(sub), .res_o(res), .ovf_o(ovf)
  );

  task automatic cyc(input int a, input int b, input logic s_acc, input logic s_sub);
    @(negedge clk);
    opa = W'(a); opb = W'(b); acc = s_acc; sub = s_sub;
  endtask

  task automatic chk(input string req, input int exp_res, input logic exp_ovf);
    checks++;
    if (res !== W'(exp_res) || ovf !== exp_ovf) begin
      errors++;
      $display("FAIL %s: res=%0d ovf=%0b expected res=%0d ovf=%0b",
               req, $signed(res), ovf, $signed(W'(exp_res)), exp_ovf);
    end
  endtask

  // R6: hold nonzero inputs through reset and after release
  task automatic t_reset();
    opa = 16'd1234; opb = 16'd777; acc = 1'b1; sub = 1'b1;
    #7;
    chk("R6 during reset", 0, 1'b0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk("R6 first result from cleared regs", 0, 1'b0);
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R6 async clear", 0, 1'b0);
    @(negedge clk); rst_ni = 1'b1;
  endtask

  // R1 R2 R8 R4 R3 R10: back-to-back chain
  task automatic t_chain();
    cyc(54, 1850, 0, 0);
    cyc(132, 63, 0, 1);
    cyc(0, 0, 0, 0);       chk("R1 add 54+1850", 1904, 1'b0);
    cyc(750, 120, 0, 1);   chk("R2 sub 132-63", 69, 1'b0);
    cyc(0, 7000, 1, 0);    chk("R8 clear", 0, 1'b0);
    cyc(0, 30000, 1, 0);   chk("R2 sub 750-120", 630, 1'b0);
    cyc(0, 0, 0, 0);       chk("R4 acc 630+7000", 7630, 1'b0);
    cyc(0, 0, 0, 0);       chk("R3 R10 acc 7630+30000 wraps", 37630 - 65536, 1'b1);
    cyc(0, 0, 0, 0);       chk("R7 flag drops", 0, 1'b0);
  endtask

  // R5: two edges from input to output
  task automatic t_latency();
    cyc(5, 6, 0, 0);  chk("R5 before capture", 0, 1'b0);
    cyc(0, 0, 0, 0);  chk("R5 after capture only", 0, 1'b0);
    cyc(0, 0, 0, 0);  chk("R5 after result edge", 11, 1'b0);
  endtask

  // R3: edge operands
  task automatic t_edges();
    cyc(-32768, 1, 0, 1);
    cyc(32767, 1, 0, 0);
    cyc(-1, -32768, 0, 1);  chk("R3 min-1", 32767, 1'b1);
    cyc(-32768, -1, 0, 0);  chk("R3 max+1", -32768, 1'b1);
    cyc(0, 0, 0, 0);        chk("R3 -1-min no overflow", 32767, 1'b0);
    cyc(0, 0, 0, 0);        chk("R3 min+-1 overflow", 32767, 1'b1);
  endtask

  // R7: overflow then in-range accumulate
  task automatic t_nonsticky();
    cyc(32767, 0, 0, 0);
    cyc(0, 1, 1, 0);
    cyc(0, 5, 1, 0);  chk("R7 load max", 32767, 1'b0);
    cyc(0, 0, 0, 0);  chk("R7 wrap", -32768, 1'b1);
    cyc(0, 0, 0, 0);  chk("R7 cleared next op", -32763, 1'b0);
  endtask

  // R9: accumulate with subtract
  task automatic t_acc_sub();
    cyc(100, 0, 0, 0);
    cyc(0, 30, 1, 1);
    cyc(0, -50, 1, 1);  chk("R9 load 100", 100, 1'b0);
    cyc(0, 0, 0, 0);    chk("R9 100-30", 70, 1'b0);
    cyc(0, 0, 0, 0);    chk("R9 70-(-50)", 120, 1'b0);
  endtask

  initial begin
    t_reset();
    t_chain();
    t_latency();
    t_edges();
    t_nonsticky();
    t_acc_sub();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule